// File: doc/BRIEF.md
# Bus Listener Handshake Acceptor

This block is the receiving side of a three-wire byte handshake on a parallel instrument bus. A host processor runs every step of the handshake itself. It writes two control flags: one holds the not-ready-for-data line low, the other holds the not-data-accepted line low. The block turns those flags into open-drain pull-low enables. It watches the talker's data-valid line and the eight data lines. It raises an interrupt only when the bus reaches the condition the host's current step is waiting for.

Two conditions raise the interrupt. The first is data-valid going active while the not-data-accepted line is still held low. The second is data-valid going away while the not-ready line is held low. Both feed one interrupt output. The host reads a status word to tell them apart, and reads the captured byte at a second address. Data-valid passes through a synchronizer before any logic uses it. The byte is latched at the first cycle where the synchronized data-valid shows active.

One byte takes these steps:
1. The host answers the first interrupt by pulling NRFD low.
2. It then releases NDAC. This tells the talker the byte was taken and clears the first interrupt.
3. When the talker withdraws data-valid, the second interrupt fires.
4. The host pulls NDAC low again.
5. It then releases NRFD, which clears the second interrupt.

Top module: `listener_handshake`

## Requirements
- R1: After reset, the NRFD pull-low enable is 0, the NDAC pull-low enable is 1 and `irq` is 0. The status word (read address 0) is 4'b0001. The captured byte (read address 1) is 0.
- R2: A write to address 0 stores `hostWrData[1]` as the nrfd flag and `hostWrData[0]` as the ndac flag. `nrfdPullLow` and `ndacPullLow` equal these flags from the clock edge of the write onward.
- R3: Assume `davN` goes low while the ndac flag is 1. Then status bit 3 (valid pending) and `irq` go to 1 after the third rising clock edge that follows, and not before.
- R4: Read address 1 returns the inverse of `dataLinesN`, captured at the same edge where valid pending sets. The data lines are active low.
- R5: Assume the ndac flag is 0 during a clock edge. Then the valid pending bit is 0 after the next edge, and `irq` drops with it if no other source is pending.
- R6: Assume `davN` goes high while the nrfd flag is 1. Then status bit 2 (release pending) and `irq` go to 1 after the third rising edge that follows, and not before. Valid pending and release pending are never 1 together.
- R7: Assume the nrfd flag is 0 during a clock edge. Then release pending is 0 after the next edge.
- R8: A write to address 1 has no effect on the flags, the pull-low enables or the status word.
- R9: Once a byte has been captured, changes on `dataLinesN` while `davN` stays low leave read address 1 unchanged.
- R10: If `davN` goes low while the ndac flag is 0, valid pending stays 0 and `irq` stays 0. Status bit 1 is the nrfd flag and bit 0 is the ndac flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 1 | Host write address (0 = control flags) |
| hostWrData | input | 2 | Bit 1 = nrfd flag, bit 0 = ndac flag |
| hostRdAddr | input | 1 | Host read address (0 = status, 1 = byte) |
| hostRdData | output | DATA_W | Read data, combinational from read address |
| davN | input | 1 | Data-valid bus line, active low |
| dataLinesN | input | DATA_W | Data bus lines, active low |
| nrfdPullLow | output | 1 | Pull-low enable for the not-ready line |
| ndacPullLow | output | 1 | Pull-low enable for the not-accepted line |
| irq | output | 1 | Combined interrupt request |

## Verification
Results are due at these delays:
- A flag write shows on the pull-low enables right after its own edge.
- A flag write reaches the pending bits and `irq` one edge later.
- A change on `davN` reaches the pending bits, `irq` and the captured byte after three edges: two synchronizer stages, then the pending register.

The bench drives all stimulus at falling edges. It counts rising edges to the due cycle and samples there. It also samples one edge early, to confirm nothing arrives ahead of time. The flag sweep covers all four flag settings with `davN` both high and low.

// File: rtl/lh_pkg.sv
package lh_pkg;
  localparam int STATUS_W = 4;

  typedef struct packed {
    logic                captureByte;
    logic [STATUS_W-1:0] status;
  } lhStrobes_t;
endpackage

// File: rtl/lh_control.sv
module lh_control
  import lh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic       hostAddr,
  input  logic [1:0] hostWrData,
  input  logic       davAsserted,
  input  logic       davRise,
  output logic       nrfdFlag,
  output logic       ndacFlag,
  output logic       validPend,
  output logic       releasedPend,
  output lhStrobes_t strobes,
  output logic       irq
);
  // Host-owned flags; address 0 is the only writable location
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nrfdFlag <= 1'b0;
      ndacFlag <= 1'b1;
    end else if (hostWrEn && !hostAddr) begin
      nrfdFlag <= hostWrData[1];
      ndacFlag <= hostWrData[0];
    end
  end

  // Qualified interrupt sources, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPend    <= 1'b0;
      releasedPend <= 1'b0;
    end else begin
      validPend    <= davAsserted & ndacFlag;
      releasedPend <= ~davAsserted & nrfdFlag;
    end
  end

  always_comb begin
    strobes.captureByte = davRise;
    strobes.status      = {validPend, releasedPend, nrfdFlag, ndacFlag};
    irq                 = validPend | releasedPend;
  end
endmodule

// File: rtl/lh_datapath.sv
module lh_datapath
  import lh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              davN,
  input  logic [DATA_W-1:0] dataLinesN,
  input  lhStrobes_t        strobes,
  input  logic              hostRdAddr,
  output logic              davAsserted,
  output logic              davRise,
  output logic [DATA_W-1:0] hostRdData
);
  localparam int PAD_W = DATA_W - STATUS_W;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   davPrev;
  logic [DATA_W-1:0]      holdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      davPrev   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], ~davN};
      davPrev   <= syncChain[SYNC_STAGES-1];
    end
  end

  assign davAsserted = syncChain[SYNC_STAGES-1];
  assign davRise     = davAsserted & ~davPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    holdByte <= '0;
    else if (strobes.captureByte) holdByte <= ~dataLinesN;
  end

  always_comb begin
    if (hostRdAddr) hostRdData = holdByte;
    else            hostRdData = {{PAD_W{1'b0}}, strobes.status};
  end
endmodule

// File: rtl/listener_handshake.sv
module listener_handshake
  import lh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostAddr,
  input  logic [1:0]        hostWrData,
  input  logic              hostRdAddr,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              davN,
  input  logic [DATA_W-1:0] dataLinesN,
  output logic              nrfdPullLow,
  output logic              ndacPullLow,
  output logic              irq
);
  lhStrobes_t strobes;
  logic davAsserted, davRise, nrfdFlag, ndacFlag, validPend, releasedPend;

  lh_control u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .davAsserted(davAsserted), .davRise(davRise),
    .nrfdFlag(nrfdFlag), .ndacFlag(ndacFlag), .validPend(validPend),
    .releasedPend(releasedPend), .strobes(strobes), .irq(irq)
  );

  lh_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .davN(davN), .dataLinesN(dataLinesN),
    .strobes(strobes), .hostRdAddr(hostRdAddr), .davAsserted(davAsserted),
    .davRise(davRise), .hostRdData(hostRdData)
  );

  // Open-drain: enables only ever pull low
  assign nrfdPullLow = nrfdFlag;
  assign ndacPullLow = ndacFlag;
endmodule

// File: rtl/lh_checker.sv
module lh_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic       hostAddr,
  input logic [1:0] hostWrData,
  input logic       nrfdPullLow,
  input logic       ndacPullLow,
  input logic       validPend,
  input logic       releasedPend
);
  a_r2_flags_follow_write: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !hostAddr) |=>
      (nrfdPullLow == $past(hostWrData[1]) && ndacPullLow == $past(hostWrData[0])));

  a_r5_ndac_clear_drops_valid: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ndacPullLow) |-> !validPend);

  a_r7_nrfd_clear_drops_release: assert property (@(posedge clk) disable iff (!rstN)
    $past(!nrfdPullLow) |-> !releasedPend);

  a_r8_readonly_addr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr) |=> $stable({nrfdPullLow, ndacPullLow}));

  a_r6_sources_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({validPend, releasedPend}));
endmodule

bind listener_handshake lh_checker u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .nrfdPullLow(nrfdPullLow), .ndacPullLow(ndacPullLow),
  .validPend(validPend), .releasedPend(releasedPend)
);

// File: tb/sim_listener_handshake.sv
module sim_listener_handshake;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostAddr = 1'b0, hostRdAddr = 1'b0;
  logic [1:0] hostWrData = 2'b00;
  logic [DW-1:0] hostRdData;
  logic davN = 1'b1;
  logic [DW-1:0] dataLinesN = '1;
  logic nrfdPullLow, ndacPullLow, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  listener_handshake u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdAddr(hostRdAddr), .hostRdData(hostRdData),
    .davN(davN), .dataLinesN(dataLinesN), .nrfdPullLow(nrfdPullLow),
    .ndacPullLow(ndacPullLow), .irq(irq)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic a, input logic [1:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    tick(1);
    hostWrEn = 1'b0;
  endtask

  function automatic int rd(input logic a);
    hostRdAddr = a;
    return int'(hostRdData);
  endfunction

  task automatic readCheck(input string req, input logic a, input int exp);
    hostRdAddr = a;
    #1;
    check(req, int'(hostRdData), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] b;
    tick(2);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 nrfd", nrfdPullLow, 0);
    check("R1 ndac", ndacPullLow, 1);
    check("R1 irq", irq, 0);
    readCheck("R1 status", 1'b0, 1);
    readCheck("R1 byte", 1'b1, 0);

    // Flag sweep: every flag setting with DAV both ways (R2, R3, R5, R6, R7, R10)
    for (int dv = 0; dv < 2; dv++) begin
      davN = (dv == 0);
      tick(4);
      for (int f = 0; f < 4; f++) begin
        hostWrite(1'b0, f[1:0]);
        check("R2 pins", {nrfdPullLow, ndacPullLow}, f);
        tick(1);
        readCheck("R10 sweep status", 1'b0,
          ((dv & f) << 3) | (((1 - dv) & (f >> 1)) << 2) | f);
        check("R5 R7 sweep irq", irq, (dv & f & 1) | ((1 - dv) & (f >> 1)));
      end
    end
    davN = 1'b1;
    hostWrite(1'b0, 2'b01);
    tick(4);

    // Full handshake over a sweep of byte values
    for (int k = 0; k < 24; k++) begin
      b = DW'((k * 37 + 5) ^ (k << 4));
      dataLinesN = ~b;
      davN = 1'b0;
      tick(2);
      check("R3 not early", irq, 0);
      tick(1);
      check("R3 irq", irq, 1);
      readCheck("R3 status", 1'b0, 4'b1001);
      readCheck("R4 byte", 1'b1, int'(b));
      dataLinesN = DW'(~k);  // R9: lines move while DAV held
      hostWrite(1'b0, 2'b11);
      hostWrite(1'b0, 2'b10);
      tick(1);
      check("R5 irq cleared", irq, 0);
      check("R5 ndac released", ndacPullLow, 0);
      readCheck("R9 byte held", 1'b1, int'(b));
      davN = 1'b1;
      tick(2);
      check("R6 not early", irq, 0);
      tick(1);
      check("R6 irq", irq, 1);
      readCheck("R6 status", 1'b0, 4'b0110);
      hostWrite(1'b0, 2'b11);
      hostWrite(1'b0, 2'b01);
      tick(1);
      check("R7 irq cleared", irq, 0);
      readCheck("R7 status", 1'b0, 4'b0001);
    end

    // R8: write to read-only address
    hostWrite(1'b1, 2'b10);
    tick(1);
    check("R8 pins", {nrfdPullLow, ndacPullLow}, 2'b01);
    readCheck("R8 status", 1'b0, 4'b0001);

    // R10: DAV while ndac released
    hostWrite(1'b0, 2'b00);
    davN = 1'b0;
    tick(5);
    check("R10 irq", irq, 0);
    readCheck("R10 status", 1'b0, 4'b0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule